// File: doc/BRIEF.md
# Bus Hold Request/Grant Sequencer

This block lets a bus master that asks for the bus with a steady level take it over from a processor. The processor uses one shared, active-low, open-drain wire for both directions of the handshake. When the level request appears, the block pulls the wire low for one clock. It then waits for the processor to pull the same wire low for its grant. After the grant it raises a level acknowledge towards the bus. When the level request drops, the block pulls the wire low for one more clock to hand the bus back, and it lowers the acknowledge in that same clock.

The wire is modelled with two signals. One is a pull-enable output, high when the block pulls the line low. The other is an input that samples the resolved line level. The hold request is sampled on the falling clock edge. All sequencing happens on the rising edge. After a release pulse the block waits for a short settle gap, a number of clocks set by a parameter, before it will take a new request.

Top module: `hold_grant_seq`

## Requirements
- R1: While the synchronous reset is high, and in the first clock after it, the pull-enable and the acknowledge are both low.
- R2: The hold request is sampled on the falling clock edge. When the block is idle and the sampled request is high, the pull-enable is high for exactly one clock, starting at the next rising edge.
- R3: After the request pulse, a low line level (input 0) seen at a rising edge while the block is not pulling raises the acknowledge from that edge on.
- R4: A low line level during the clock in which the block itself pulls the line is not taken as a grant, and the acknowledge stays low.
- R5: When the sampled request is low while the acknowledge is high, at the next rising edge the acknowledge falls and the pull-enable is high for exactly one clock.
- R6: After the release pulse ends, a sampled request is ignored for GAP_CLKS clocks (default 1). Only after that gap does the next request pulse start.
- R7: A low line level while the block is idle, or while it holds the acknowledge, causes no pulse and does not change the acknowledge.
- R8: The pull-enable and the acknowledge are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; request sampled on falling edge, sequencing on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_i | input | 1 | Level bus hold request |
| line_i | input | 1 | Sampled level of the shared request/grant line (0 = low) |
| line_pull_o | output | 1 | High to pull the shared line low |
| hold_ack_o | output | 1 | Level hold acknowledge to the bus |

## Verification
The hardest case to reach is a low line level that overlaps the block's own pull clock, because from the ports it looks just like a grant. Directed stimulus places a processor pull exactly across the request pulse. After that, stimulus drops and raises the request inside the settle gap. A long run with a fixed seed then lets processor pulls and request changes land in every phase. A cycle model in the bench checks every clock.

// File: rtl/hold_grant_seq.sv
module hold_grant_seq #(
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_i,
  input  logic line_i,
  output logic line_pull_o,
  output logic hold_ack_o
);
  localparam int GW = $clog2(GAP_CLKS + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_HELD, S_REL, S_GAP} st_t;

  st_t           st;
  logic          req_s;
  logic [GW-1:0] gap_cnt;

  always_ff @(negedge clk) begin
    if (rst) req_s <= 1'b0;
    else     req_s <= hold_req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      gap_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_s) st <= S_REQ;
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (!line_i) st <= S_HELD;
        S_HELD: if (!req_s) st <= S_REL;
        S_REL: begin
          st      <= S_GAP;
          gap_cnt <= GW'(1);
        end
        S_GAP: begin
          if (gap_cnt >= GW'(GAP_CLKS)) st <= S_IDLE;
          else gap_cnt <= gap_cnt + GW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign line_pull_o = (st == S_REQ) || (st == S_REL);
  assign hold_ack_o  = (st == S_HELD);
endmodule

module hold_grant_seq_chk (
  input logic clk,
  input logic rst,
  input logic line_i,
  input logic line_pull_o,
  input logic hold_ack_o
);
  // R2
  pull_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    line_pull_o |=> !line_pull_o);
  // R3
  ack_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_o) |-> ($past(!line_i) && $past(!line_pull_o)));
  // R4
  no_ack_after_pull_chk: assert property (@(posedge clk) disable iff (rst)
    line_pull_o |=> !hold_ack_o);
  // R5
  drop_with_pull_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_o) |-> line_pull_o);
  // R8
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_pull_o && hold_ack_o));
endmodule

bind hold_grant_seq hold_grant_seq_chk u_chk (
  .clk(clk), .rst(rst), .line_i(line_i),
  .line_pull_o(line_pull_o), .hold_ack_o(hold_ack_o)
);

// File: tb/hold_grant_seq_tb.sv
module hold_grant_seq_tb;
  localparam int GAP = 1;
  logic clk = 1'b0, rst = 1'b1, hold = 1'b0, cpu_pull = 1'b0;
  logic pull, ack;
  wire  line = !(pull || cpu_pull);
  int   tests = 0, fails = 0;
  bit   armed = 1'b0, done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  hold_grant_seq #(.GAP_CLKS(GAP)) u_dut (
    .clk(clk), .rst(rst), .hold_req_i(hold), .line_i(line),
    .line_pull_o(pull), .hold_ack_o(ack)
  );

  // cycle model: 0 idle,1 req,2 wait,3 held,4 rel,5 gap
  logic m_req = 1'b0;
  int   ms = 0, mg = 0;

  function automatic logic exp_pull(int s); return (s == 1) || (s == 4); endfunction
  function automatic logic exp_ack(int s);  return s == 3; endfunction
  function automatic int nxt(int s, logic r, logic ln, int g);
    case (s)
      0: return r ? 1 : 0;
      1: return 2;
      2: return ln ? 2 : 3;
      3: return r ? 3 : 4;
      4: return 5;
      default: return (g >= GAP) ? 0 : 5;
    endcase
  endfunction

  always @(negedge clk) m_req <= rst ? 1'b0 : hold;
  always @(posedge clk) begin
    if (rst) begin ms <= 0; mg <= 0; end
    else begin
      ms <= nxt(ms, m_req, line, mg);
      if (ms == 4) mg <= 1; else if (ms == 5 && mg < GAP) mg <= mg + 1;
    end
  end

  task automatic check(string t, logic a, logic e, string what);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", t, what, a, e);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (armed && !rst) begin
      check(tag, pull, exp_pull(ms), "pull");
      check(tag, ack, exp_ack(ms), "ack");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R1", pull, 1'b0, "pull in reset");
    check("R1", ack, 1'b0, "ack in reset");
    rst = 1'b0;
    armed = 1'b1;
    @(posedge clk); #1;
    check("R1", pull, 1'b0, "pull after reset");
    check("R1", ack, 1'b0, "ack after reset");
    cyc(1);
    tag = "R7 idle";
    cpu_pull = 1'b1; cyc(2); cpu_pull = 1'b0; cyc(2);
    tag = "R2 R4";
    hold = 1'b1; cyc(1);
    cpu_pull = 1'b1; cyc(1);
    cpu_pull = 1'b0; cyc(3);
    check("R4", ack, 1'b0, "ack after own pulse");
    tag = "R3";
    cpu_pull = 1'b1; cyc(1); cpu_pull = 1'b0; cyc(2);
    check("R3", ack, 1'b1, "ack after grant");
    tag = "R7 held";
    cpu_pull = 1'b1; cyc(2); cpu_pull = 1'b0; cyc(2);
    check("R7", ack, 1'b1, "ack kept while held");
    tag = "R5 R6";
    hold = 1'b0; cyc(1);
    hold = 1'b1; cyc(6);
    tag = "R3 grant2";
    cpu_pull = 1'b1; cyc(1); cpu_pull = 1'b0; cyc(2);
    hold = 1'b0; cyc(4);
    tag = "R8 random";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) hold = ~hold;
      cpu_pull = ($urandom_range(0, 3) == 0);
      cyc(1);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule